// File: doc/BRIEF.md
# Dual-Width Condition-Code ALU

This block is a 64-bit integer arithmetic and logic unit that computes two sets of condition flags from a single operation: one set judged on the low 32 bits of the result and one set judged on the full 64 bits. Both sets are packed into one 8-bit condition-code word. It handles add and subtract, with and without an incoming carry, six bitwise operations and tagged add and subtract. Tagged arithmetic treats nonzero low tag bits on either operand as an overflow. The trapping tagged forms turn that overflow into a fault.

The arithmetic core is purely combinational. A single output register sits behind a valid/ready stream interface. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented one cycle later with `out_valid` high and stays unchanged until the consumer takes it with `out_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure from `out_ready` reaches the producer in the same cycle and stalls it. An accepted operation is never dropped or duplicated.

Opcodes (4 bits): 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 and, 5 or, 6 xor, 7 and-not (a & ~b), 8 or-not (a | ~b), 9 xnor, 10 tagged add, 11 tagged subtract, 12 tagged add with trap, 13 tagged subtract with trap. Codes 14 and 15 are undefined.

Top module: `alu_cc_stream`

## Requirements
- R1: The flag word holds the 64-bit set in bits 7:4 and the 32-bit set in bits 3:0. Inside each nibble, N is bit 3, Z is bit 2, V is bit 1 and C is bit 0.
- R2: Add (opcode 0) returns a+b modulo 2^64. The 32-bit C is the carry out of the sum of the two low 32-bit halves, and the 64-bit C is the carry out of bit 63.
- R3: For add, V is set when both operands have the same sign and the result's sign differs from it. The sign is bit 31 for the low set and bit 63 for the high set.
- R4: Subtract (opcode 2) returns a-b. C is a borrow: it is set when the unsigned first operand is smaller than the second over that set's width. V is set when the operand signs differ and the result's sign differs from the first operand's.
- R5: Add with carry (1) and subtract with carry (3) take their carry input from bit 0 of `cc_in`, computing a+b+c and a-b-c with flags defined as in R2 to R4. All other opcodes ignore `cc_in`.
- R6: The logical opcodes 4 to 9 return the bitwise result. N and Z follow that result, and V and C are cleared in both sets.
- R7: N is bit 31 (low set) or bit 63 (high set) of the result. Z is set when result bits 31:0 (low set) or 63:0 (high set) are all zero.
- R8: Tagged add and subtract (10 to 13) set the low V when bits 1:0 of either operand are nonzero, or on ordinary 32-bit signed overflow. The high V and both C flags follow R3/R4.
- R9: The trapping tagged opcodes (12, 13) raise `out_tag_fault` exactly when the low V of R8 is true. A faulting operation does not assert `out_flags_we`.
- R10: `out_flags_we` equals `cc_en` for opcodes 0 to 9 and is 1 for non-faulting tagged opcodes. Undefined opcodes 14 and 15 give result 0, flags 0, no flag write and no fault.
- R11: A result appears on the output one cycle after acceptance. It stays stable while `out_valid` is high and `out_ready` is low. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R12: While `rst_n` is low and directly after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Opcode |
| in_cc_en | input | 1 | Request a flag write (opcodes 0 to 9) |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_cc | input | 8 | Current condition-code word (bit 0 is the carry input) |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Operation result |
| out_flags | output | 8 | New condition-code word |
| out_flags_we | output | 1 | Flag word should be written |
| out_tag_fault | output | 1 | Tag-overflow fault from a trapping tagged opcode |

## Verification
Every field of an accepted operation is due on the output exactly one clock after the edge that accepted it, and it stays there until the edge on which `out_ready` is seen high. The bench settles its inputs just after each falling edge. From the settled port values it decides which transfers the next rising edge will make, and it queues the expected record when an input transfer happens. On every cycle it checks that `out_valid` matches whether that queue holds an entry. At each output transfer it checks the record against the queue head. Random gaps on both sides exercise the stall and the stability under back-pressure.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_AND   = 4'd4,
    OP_OR    = 4'd5,
    OP_XOR   = 4'd6,
    OP_ANDN  = 4'd7,
    OP_ORN   = 4'd8,
    OP_XNOR  = 4'd9,
    OP_TADD  = 4'd10,
    OP_TSUB  = 4'd11,
    OP_TADDT = 4'd12,
    OP_TSUBT = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;
endpackage

// File: rtl/alu_cc_adder.sv
// Split adder: the low LO_W bits and the upper bits are summed as two
// chained pieces so that both carry-outs are directly visible.
module alu_cc_adder #(
  parameter int DATA_W = 64,
  parameter int LO_W   = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] bx,
  input  logic              c0,
  output logic [DATA_W-1:0] sum,
  output logic              co_lo,
  output logic              co_hi,
  output logic              ov_lo,
  output logic              ov_hi
);
  localparam int HI_W = DATA_W - LO_W;

  logic [LO_W:0] part_lo;
  logic [HI_W:0] part_hi;

  always_comb begin
    part_lo = {1'b0, a[LO_W-1:0]} + {1'b0, bx[LO_W-1:0]} + {{LO_W{1'b0}}, c0};
    part_hi = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, bx[DATA_W-1:LO_W]}
            + {{HI_W{1'b0}}, part_lo[LO_W]};
    sum   = {part_hi[HI_W-1:0], part_lo[LO_W-1:0]};
    co_lo = part_lo[LO_W];
    co_hi = part_hi[HI_W];
    ov_lo = (a[LO_W-1] == bx[LO_W-1]) && (sum[LO_W-1] != a[LO_W-1]);
    ov_hi = (a[DATA_W-1] == bx[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
  end
endmodule

// File: rtl/alu_cc_logic.sv
module alu_cc_logic #(
  parameter int DATA_W = 64
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  import alu_cc_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ANDN: res = a & ~b;
      OP_ORN:  res = a | ~b;
      OP_XNOR: res = ~(a ^ b);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core #(
  parameter int DATA_W = 64,
  parameter int LO_W   = 32,
  parameter int TAG_W  = 2
) (
  input  logic [3:0]        op,
  input  logic              cc_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [7:0]        cc_in,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags,
  output logic              flags_we,
  output logic              tag_fault
);
  import alu_cc_pkg::*;

  localparam int NSETS = 2;

  logic is_sub, use_cin, is_arith, is_logic, is_tag, is_trap, known;
  logic cin_eff, c0, tag_bad, tag_ov;
  logic [DATA_W-1:0] bx, sum, lres;
  logic co_lo, co_hi, ov_lo, ov_hi;
  logic [NSETS-1:0] co_set, ov_set;
  nzvc_t [NSETS-1:0] set_flags;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_TSUB) || (op == OP_TSUBT);
    use_cin  = (op == OP_ADDC) || (op == OP_SUBC);
    is_tag   = (op >= OP_TADD) && (op <= OP_TSUBT);
    is_trap  = (op == OP_TADDT) || (op == OP_TSUBT);
    is_arith = (op <= OP_SUBC) || is_tag;
    is_logic = (op >= OP_AND) && (op <= OP_XNOR);
    known    = is_arith || is_logic;
    cin_eff  = use_cin & cc_in[0];
    c0       = is_sub ? ~cin_eff : cin_eff;
    bx       = is_sub ? ~b : b;
    tag_bad  = (|a[TAG_W-1:0]) | (|b[TAG_W-1:0]);
  end

  alu_cc_adder #(.DATA_W(DATA_W), .LO_W(LO_W)) u_add (
    .a(a), .bx(bx), .c0(c0), .sum(sum),
    .co_lo(co_lo), .co_hi(co_hi), .ov_lo(ov_lo), .ov_hi(ov_hi)
  );

  alu_cc_logic #(.DATA_W(DATA_W)) u_log (
    .op(op), .a(a), .b(b), .res(lres)
  );

  always_comb begin
    result = is_arith ? sum : (is_logic ? lres : '0);
    co_set = {co_hi, co_lo};
    ov_set = {ov_hi, ov_lo};
    tag_ov = is_tag & (tag_bad | ov_lo);
  end

  // One flag set per width; set 0 judges LO_W bits, set 1 the full word.
  for (genvar g = 0; g < NSETS; g++) begin : g_set
    localparam int SPAN = (g == 0) ? LO_W : DATA_W;
    always_comb begin
      set_flags[g].n = known & result[SPAN-1];
      set_flags[g].z = known & ~(|result[SPAN-1:0]);
      set_flags[g].c = is_arith & (co_set[g] ^ is_sub);
      if (g == 0) set_flags[g].v = is_arith & (ov_set[g] | tag_ov);
      else        set_flags[g].v = is_arith & ov_set[g];
    end
  end

  always_comb begin
    flags     = set_flags;
    tag_fault = is_trap & tag_ov;
    flags_we  = is_tag ? ~tag_fault : (known & cc_en);
  end
endmodule

// File: rtl/alu_cc_stream.sv
module alu_cc_stream #(
  parameter int DATA_W = 64,
  parameter int LO_W   = 32,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic              in_cc_en,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [7:0]        in_cc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [7:0]        out_flags,
  output logic              out_flags_we,
  output logic              out_tag_fault
);
  logic [DATA_W-1:0] c_result;
  logic [7:0]        c_flags;
  logic              c_we, c_fault, take;

  alu_cc_core #(.DATA_W(DATA_W), .LO_W(LO_W), .TAG_W(TAG_W)) u_core (
    .op(in_op), .cc_en(in_cc_en), .a(in_a), .b(in_b), .cc_in(in_cc),
    .result(c_result), .flags(c_flags), .flags_we(c_we), .tag_fault(c_fault)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_flags     <= '0;
      out_flags_we  <= 1'b0;
      out_tag_fault <= 1'b0;
    end else begin
      if (take) begin
        out_valid     <= 1'b1;
        out_result    <= c_result;
        out_flags     <= c_flags;
        out_flags_we  <= c_we;
        out_tag_fault <= c_fault;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu_cc_stream_chk.sv
module alu_cc_stream_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [7:0]        out_flags,
  input logic              out_flags_we,
  input logic              out_tag_fault
);
  assert_reset_empty_R12: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags)
      && $stable(out_flags_we) && $stable(out_tag_fault));

  assert_accept_shows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_fault_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tag_fault |-> !out_flags_we);

  assert_logic_clears_vc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op >= 4'd4 && in_op <= 4'd9 |=>
      out_flags[1:0] == 2'b00 && out_flags[5:4] == 2'b00);

  assert_zero_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags_we |-> out_flags[6] == (out_result == '0));

  assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags_we |-> out_flags[2] == (out_result[31:0] == 32'd0));
endmodule

bind alu_cc_stream alu_cc_stream_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_flags(out_flags),
  .out_flags_we(out_flags_we), .out_tag_fault(out_tag_fault)
);

// File: tb/alu_cc_stream_test.sv
`timescale 1ns/1ps
module alu_cc_stream_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_cc_en = 1'b0, out_ready = 1'b0;
  logic [3:0] in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic [7:0] in_cc = '0;
  logic in_ready, out_valid, out_flags_we, out_tag_fault;
  logic [63:0] out_result;
  logic [7:0] out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit in_reset = 1'b1;

  typedef struct packed {
    logic [3:0] op;
    logic fault;
    logic we;
    logic [7:0] flags;
    logic [63:0] res;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  alu_cc_stream uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_cc_en(in_cc_en), .in_a(in_a), .in_b(in_b), .in_cc(in_cc),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .out_flags_we(out_flags_we), .out_tag_fault(out_tag_fault)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    if (op == 4'd0) return "R2/R3";
    if (op == 4'd2) return "R4";
    if (op == 4'd1 || op == 4'd3) return "R5";
    if (op >= 4'd4 && op <= 4'd9) return "R6";
    if (op == 4'd10 || op == 4'd11) return "R8";
    if (op == 4'd12 || op == 4'd13) return "R9";
    return "R10";
  endfunction

  // Behavioural model of the requirements.
  function automatic exp_t model(input logic [3:0] op, input logic cen,
                                 input logic [63:0] a, input logic [63:0] b, input logic [7:0] cc);
    exp_t e;
    logic [64:0] wide;
    logic [32:0] narrow;
    logic cin, c32, c64, v32, v64, tagv, arith, sub;
    logic [63:0] r;
    e = '0;
    e.op = op;
    cin = (op == 4'd1 || op == 4'd3) ? cc[0] : 1'b0;
    sub = (op == 4'd2 || op == 4'd3 || op == 4'd11 || op == 4'd13);
    arith = (op <= 4'd3) || (op >= 4'd10 && op <= 4'd13);
    c32 = 0; c64 = 0; v32 = 0; v64 = 0; r = '0;
    if (arith && !sub) begin
      wide = {1'b0, a} + {1'b0, b} + {64'd0, cin};
      narrow = {1'b0, a[31:0]} + {1'b0, b[31:0]} + {32'd0, cin};
      r = wide[63:0]; c64 = wide[64]; c32 = narrow[32];
      v32 = (a[31] == b[31]) && (r[31] != a[31]);
      v64 = (a[63] == b[63]) && (r[63] != a[63]);
    end else if (arith) begin
      r = a - b - {63'd0, cin};
      c64 = ({1'b0, a} < ({1'b0, b} + {64'd0, cin}));
      c32 = ({1'b0, a[31:0]} < ({1'b0, b[31:0]} + {32'd0, cin}));
      v32 = (a[31] != b[31]) && (r[31] != a[31]);
      v64 = (a[63] != b[63]) && (r[63] != a[63]);
    end else begin
      case (op)
        4'd4: r = a & b;
        4'd5: r = a | b;
        4'd6: r = a ^ b;
        4'd7: r = a & ~b;
        4'd8: r = a | ~b;
        4'd9: r = ~(a ^ b);
        default: r = '0;
      endcase
    end
    tagv = (op >= 4'd10 && op <= 4'd13) && ((a[1:0] != 0) || (b[1:0] != 0) || v32);
    if (op >= 4'd10 && op <= 4'd13) v32 = tagv;
    e.res = r;
    if (op <= 4'd13) begin
      e.flags = {r[63], r == 64'd0, v64, c64, r[31], r[31:0] == 32'd0, v32, c32};
      e.fault = (op >= 4'd12) && tagv;
      e.we = (op >= 4'd10) ? !e.fault : cen;
    end
    return e;
  endfunction

  // Per-cycle comparison: inputs settle after the falling edge, then the
  // transfers that the next rising edge will make are evaluated.
  task automatic step(input bit v, input logic [3:0] op, input bit cen,
                      input logic [63:0] a, input logic [63:0] b, input logic [7:0] cc, input bit rdy);
    exp_t h;
    @(negedge clk);
    in_valid = v; in_op = op; in_cc_en = cen; in_a = a; in_b = b; in_cc = cc; out_ready = rdy;
    #1;
    if (!in_reset) begin
      check(out_valid == (q.size() > 0), "R11 valid", {63'd0, out_valid}, {63'd0, q.size() > 0});
      check(in_ready == (!out_valid || out_ready), "R11 ready", {63'd0, in_ready}, {63'd0, !out_valid || out_ready});
      if (out_valid && out_ready && q.size() > 0) begin
        h = q.pop_front();
        check(out_result == h.res, {req_of(h.op), " result"}, out_result, h.res);
        check(out_flags == h.flags, {"R1 ", req_of(h.op), " flags"}, {56'd0, out_flags}, {56'd0, h.flags});
        check(out_flags_we == h.we, "R10 we", {63'd0, out_flags_we}, {63'd0, h.we});
        check(out_tag_fault == h.fault, "R9 fault", {63'd0, out_tag_fault}, {63'd0, h.fault});
      end
      if (in_valid && in_ready) q.push_back(model(op, cen, a, b, cc));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R12 reset", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    in_reset = 1'b0;
    // Directed corners
    step(1, 4'd0, 1, 64'h0000_0000_FFFF_FFFF, 64'd1, 8'h00, 1);          // R2 low carry
    step(1, 4'd0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'hFF, 1);          // R2 64 carry, cc ignored R5
    step(1, 4'd0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 8'h00, 1);          // R3 64 overflow
    step(1, 4'd0, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, 8'h00, 1);          // R3 low overflow, R10 no write
    step(1, 4'd2, 1, 64'd1, 64'd2, 8'h00, 1);                            // R4 borrow
    step(1, 4'd2, 1, 64'h8000_0000_0000_0000, 64'd1, 8'h00, 1);          // R4 overflow
    step(1, 4'd1, 1, 64'hFFFF_FFFF, 64'd0, 8'h01, 1);                    // R5 add with carry
    step(1, 4'd3, 1, 64'd5, 64'd5, 8'h01, 1);                            // R5 subtract with carry
    step(1, 4'd3, 1, 64'd5, 64'd5, 8'hFE, 1);                            // R5 bit 0 only
    step(1, 4'd4, 1, 64'hFFFF_0000_0000_0000, 64'h0000_FFFF_FFFF_FFFF, 8'h00, 1); // R6/R7 zero
    step(1, 4'd9, 1, 64'h0, 64'h0, 8'h00, 1);                            // R6 xnor all ones
    step(1, 4'd8, 1, 64'h1, 64'hFFFF_FFFF_0000_0000, 8'h00, 1);          // R7 low zero? no
    step(1, 4'd4, 1, 64'h1_0000_0000, 64'h1_0000_0000, 8'h00, 1);        // R7 low zero, high not
    step(1, 4'd10, 0, 64'd4, 64'd8, 8'h00, 1);                           // R8 clean tags
    step(1, 4'd10, 0, 64'd5, 64'd8, 8'h00, 1);                           // R8 tag bits
    step(1, 4'd11, 0, 64'd8, 64'd2, 8'h00, 1);                           // R8 tagged subtract
    step(1, 4'd12, 0, 64'd4, 64'd3, 8'h00, 1);                           // R9 trap
    step(1, 4'd13, 0, 64'd12, 64'd4, 8'h00, 1);                          // R9 no trap
    step(1, 4'd12, 0, 64'h7FFF_FFFC, 64'd4, 8'h00, 1);                   // R9 trap on overflow
    step(1, 4'd14, 1, 64'd3, 64'd3, 8'hFF, 1);                           // R10 undefined
    step(1, 4'd15, 1, 64'd3, 64'd3, 8'hFF, 0);                           // R10 undefined, stall
    step(0, 4'd0, 0, 64'd0, 64'd0, 8'h00, 0);                            // R11 hold
    step(1, 4'd0, 1, 64'd9, 64'd9, 8'h00, 0);                            // R11 back-pressure
    step(0, 4'd0, 0, 64'd0, 64'd0, 8'h00, 1);
    step(0, 4'd0, 0, 64'd0, 64'd0, 8'h00, 1);
    // Random traffic with gaps on both sides
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (i % 5 == 0) ra[63:32] = 32'hFFFF_FFFF;
      if (i % 7 == 0) rb[1:0] = 2'b00;
      step(($urandom % 4) != 0, 4'($urandom % 16), 1'($urandom), ra, rb,
           8'($urandom), ($urandom % 3) != 0);
    end
    for (int i = 0; i < 4; i++) step(0, 4'd0, 0, 64'd0, 64'd0, 8'h00, 1);
    check(q.size() == 0, "R11 drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule